// File: doc/BRIEF.md
# Iterative Multi-Width Shift Unit

This block is the shift and rotate execution unit of a small accumulator datapath. A caller presents an operand, a width select (8, 16 or 32 bits), an operation code, an 8-bit shift count and a carry input, then pulses `start`. The unit moves the operand one bit position per clock until the count is used up. After a fixed overhead it presents the result together with negative, zero, carry and sticky flags, and pulses `done` for one cycle.

Only the low bits of the operand that belong to the selected width take part. The result is returned zero-extended to 32 bits. The operation code selects one of eight forms. Three are count-driven: arithmetic right, logical right and logical left. Three move by exactly one bit: arithmetic right, logical right and logical left. The last two rotate a byte by one position through the carry. Operand fetch and write-back are the caller's job.

Top module: `shift_unit`

## Requirements
- R1: For count-driven operations (op 2 = arithmetic right, op 3 = logical right, op 4 = logical left) at width 0 (byte) or 1 (word), `done` rises exactly 6 clock edges after the accepting edge when the count is 0, and exactly 5 + count edges after it otherwise.
- R2: For count-driven operations at width 2 or 3 (both mean 32-bit long word), `done` rises 6 edges after the accepting edge when the count is 0, and 6 + count edges after it otherwise.
- R3: The one-bit operations (op 5 = arithmetic right, op 6 = logical right, op 7 = logical left) ignore `count`. They shift by exactly one bit at the selected width, and `done` rises 2 edges after acceptance. The rotates (op 0, op 1) also complete in 2 edges.
- R4: The result equals the masked operand shifted by the requested amount within the selected width. Arithmetic right shifts fill with the width's sign bit and logical shifts fill with zero. Result bits above the width are 0. A count above the width gives all-zero or all-sign.
- R5: Op 0 rotates the low byte right through carry: the result is {carry_in, a[7:1]} and C = a[0]. Op 1 rotates it left: the result is {a[6:0], carry_in} and C = a[7]. Rotates always work on 8 bits, whatever the width select.
- R6: `flag_c` is the last bit shifted out. A count of 0 returns the masked operand unchanged with `flag_c` = 0.
- R7: For right shifts, `flag_t` is 1 exactly when some bit shifted out before the last one was 1. For left shifts and rotates, `flag_t` is 0.
- R8: `flag_n` equals the top bit of the selected width of the result, and `flag_z` is 1 exactly when the result is zero.
- R9: `busy` is high from the accepting edge until `done` rises. `done` lasts one cycle with `busy` low. A `start` while busy is ignored, and the result outputs hold while busy.
- R10: After reset, `busy`, `done`, `result` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, accepted when not busy |
| width_sel | input | 2 | 0 byte, 1 word, 2 or 3 long word |
| op | input | 3 | Operation code (see R1 to R5) |
| operand | input | 32 | Value to shift |
| count | input | 8 | Shift amount for count-driven operations |
| carry_in | input | 1 | Carry entering a rotate |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| result | output | 32 | Shifted value, zero-extended |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Last bit out |
| flag_t | output | 1 | Sticky bit of right shifts |

## Verification
Every result is due a fixed number of edges after the accepting edge: 2 for rotates and one-bit forms, 6 or 5 + count for byte and word, and 6 or 6 + count for long word. The bench counts exactly that many rising edges after acceptance. It samples one time unit after each edge. On the edge before the due one it checks that `done` is still low and `busy` high, and on the due edge it checks the strobe, result and flags. A start injected mid-operation is followed by a check that no second strobe appears.

// File: rtl/shift_pkg.sv
package shift_pkg;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 8;
    localparam int TICK_W = CNT_W + 2;

    typedef enum logic [1:0] {
        WID_BYTE = 2'd0,
        WID_WORD = 2'd1,
        WID_LONG = 2'd2,
        WID_LNG2 = 2'd3
    } wid_e;

    typedef enum logic [2:0] {
        OP_RORC = 3'd0,
        OP_ROLC = 3'd1,
        OP_ASRN = 3'd2,
        OP_LSRN = 3'd3,
        OP_LSLN = 3'd4,
        OP_ASR1 = 3'd5,
        OP_LSR1 = 3'd6,
        OP_LSL1 = 3'd7
    } sop_e;

    function automatic int unsigned wid_bits(input wid_e w);
        case (w)
            WID_BYTE: return 8;
            WID_WORD: return 16;
            default:  return 32;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] wid_mask(input wid_e w);
        case (w)
            WID_BYTE: return {{(DATA_W-8){1'b0}}, 8'hFF};
            WID_WORD: return {{(DATA_W-16){1'b0}}, 16'hFFFF};
            default:  return {DATA_W{1'b1}};
        endcase
    endfunction

    function automatic logic is_rot(input sop_e o);
        return (o == OP_RORC) || (o == OP_ROLC);
    endfunction

    function automatic logic is_fixed(input sop_e o);
        return (o == OP_ASR1) || (o == OP_LSR1) || (o == OP_LSL1);
    endfunction

    function automatic logic is_right(input sop_e o);
        return (o == OP_ASRN) || (o == OP_LSRN) || (o == OP_ASR1) || (o == OP_LSR1);
    endfunction
endpackage

// File: rtl/shift_lat.sv
module shift_lat
    import shift_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int TW = TICK_W
) (
    input  sop_e          op,
    input  wid_e          wsel,
    input  logic [CW-1:0] count,
    output logic [TW-1:0] lat
);
    localparam int BASE_SHORT = 5;
    localparam int BASE_LONG  = 6;
    localparam int ZERO_LAT   = 6;
    localparam int FAST_LAT   = 2;

    logic long_w;

    always_comb begin
        long_w = (wsel == WID_LONG) || (wsel == WID_LNG2);
        if (is_rot(op) || is_fixed(op)) begin
            lat = TW'(FAST_LAT);
        end else if (count == '0) begin
            lat = TW'(ZERO_LAT);
        end else if (long_w) begin
            lat = TW'(BASE_LONG) + TW'(count);
        end else begin
            lat = TW'(BASE_SHORT) + TW'(count);
        end
    end
endmodule

// File: rtl/shift_step.sv
module shift_step
    import shift_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic [DW-1:0] cur,
    input  wid_e          wsel,
    input  sop_e          op,
    input  logic          cin,
    output logic [DW-1:0] nxt,
    output logic          bit_out
);
    logic [DW-1:0] mask;
    logic [DW-1:0] top;
    logic          sign;
    logic          fill;

    always_comb begin
        mask = wid_mask(wsel);
        top  = (mask >> 1) ^ mask;
        sign = |(cur & top);
        nxt  = cur;
        bit_out = 1'b0;
        fill = 1'b0;
        case (op)
            OP_ASRN, OP_ASR1, OP_LSRN, OP_LSR1, OP_RORC: begin
                if (op == OP_RORC)                         fill = cin;
                else if (op == OP_ASRN || op == OP_ASR1)   fill = sign;
                else                                       fill = 1'b0;
                bit_out = cur[0];
                nxt = (cur >> 1) | (fill ? top : '0);
            end
            default: begin
                fill    = (op == OP_ROLC) ? cin : 1'b0;
                bit_out = sign;
                nxt = ((cur << 1) & mask) | {{(DW-1){1'b0}}, fill};
            end
        endcase
    end
endmodule

// File: rtl/shift_unit.sv
module shift_unit
    import shift_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    width_sel,
    input  logic [2:0]    op,
    input  logic [DW-1:0] operand,
    input  logic [CW-1:0] count,
    input  logic          carry_in,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] result,
    output logic          flag_n,
    output logic          flag_z,
    output logic          flag_c,
    output logic          flag_t
);
    localparam int TW = CW + 2;

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [TW-1:0] tick;
        logic [CW-1:0] bits;
        logic [DW-1:0] work;
        logic          c;
        logic          t;
        sop_e          op;
        wid_e          wsel;
        logic [DW-1:0] res;
        logic          fn;
        logic          fz;
        logic          fc;
        logic          ft;
    } st_t;

    st_t st_d, st_q;

    sop_e          in_op;
    wid_e          in_w;
    logic [TW-1:0] lat;
    logic [DW-1:0] step_nxt;
    logic          step_out;
    logic [DW-1:0] topbit;

    assign in_op = sop_e'(op);
    assign in_w  = is_rot(in_op) ? WID_BYTE : wid_e'(width_sel);

    shift_lat #(.CW(CW), .TW(TW)) i_lat (
        .op    (in_op),
        .wsel  (in_w),
        .count (count),
        .lat   (lat)
    );

    shift_step #(.DW(DW)) i_step (
        .cur     (st_q.work),
        .wsel    (st_q.wsel),
        .op      (st_q.op),
        .cin     (st_q.c),
        .nxt     (step_nxt),
        .bit_out (step_out)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        topbit    = (wid_mask(st_q.wsel) >> 1) ^ wid_mask(st_q.wsel);
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy = 1'b1;
                st_d.op   = in_op;
                st_d.wsel = in_w;
                st_d.work = operand & wid_mask(in_w);
                st_d.bits = (is_rot(in_op) || is_fixed(in_op)) ? CW'(1) : count;
                st_d.tick = lat;
                st_d.c    = is_rot(in_op) ? carry_in : 1'b0;
                st_d.t    = 1'b0;
            end
        end else begin
            if (st_q.bits != '0) begin
                st_d.work = step_nxt;
                st_d.c    = step_out;
                st_d.bits = st_q.bits - CW'(1);
                if (is_right(st_q.op)) begin
                    st_d.t = st_q.t | st_q.c;
                end
            end
            st_d.tick = st_q.tick - TW'(1);
            if (st_q.tick == TW'(1)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.res  = st_q.work;
                st_d.fn   = |(st_q.work & topbit);
                st_d.fz   = (st_q.work == '0);
                st_d.fc   = st_q.c;
                st_d.ft   = st_q.t;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy   = st_q.busy;
    assign done   = st_q.done;
    assign result = st_q.res;
    assign flag_n = st_q.fn;
    assign flag_z = st_q.fz;
    assign flag_c = st_q.fc;
    assign flag_t = st_q.ft;
endmodule

// File: rtl/shift_unit_chk.sv
module shift_unit_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic [DW-1:0] result,
    input logic          flag_z
);
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

    assert_hold_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (done || $stable(result)));

    assert_zero_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flag_z == (result == '0)));
endmodule

bind shift_unit shift_unit_chk #(.DW(DW)) i_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy   (busy),
    .done   (done),
    .result (result),
    .flag_z (flag_z)
);

// File: tb/test_shift_unit.sv
module test_shift_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  width_sel = '0;
    logic [2:0]  op = '0;
    logic [31:0] operand = '0;
    logic [7:0]  count = '0;
    logic        carry_in = 1'b0;
    logic        busy, done, flag_n, flag_z, flag_c, flag_t;
    logic [31:0] result;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    shift_unit i_shift_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .width_sel(width_sel), .op(op),
        .operand(operand), .count(count), .carry_in(carry_in), .busy(busy),
        .done(done), .result(result), .flag_n(flag_n), .flag_z(flag_z),
        .flag_c(flag_c), .flag_t(flag_t)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected values from the requirements
    typedef struct packed {
        logic [31:0] r;
        logic n, z, c, t;
    } ref_t;

    function automatic int ref_lat(input logic [2:0] o, input logic [1:0] w, input logic [7:0] k);
        if (o <= 3'd1 || o >= 3'd5) return 2;
        if (k == 0) return 6;
        if (w >= 2'd2) return 6 + int'(k);
        return 5 + int'(k);
    endfunction

    function automatic ref_t ref_op(input logic [2:0] o, input logic [1:0] w0,
                                    input logic [31:0] a0, input logic [7:0] k, input logic ci);
        ref_t res;
        int wb;
        int nsh;
        logic [31:0] a;
        logic c, t, ob, sg;
        logic [1:0] w;
        w  = (o <= 3'd1) ? 2'd0 : w0;
        wb = (w == 0) ? 8 : (w == 1) ? 16 : 32;
        a  = (wb == 32) ? a0 : (a0 & ((32'd1 << wb) - 1));
        c  = (o <= 3'd1) ? ci : 1'b0;
        t  = 1'b0;
        nsh = (o <= 3'd1 || o >= 3'd5) ? 1 : int'(k);
        for (int i = 0; i < nsh; i++) begin
            sg = a[wb-1];
            if (o == 3'd0 || o == 3'd2 || o == 3'd3 || o == 3'd5 || o == 3'd6) begin
                ob = a[0];
                a = a >> 1;
                if (o == 3'd0) a[wb-1] = c;
                else if (o == 3'd2 || o == 3'd5) a[wb-1] = sg;
                if (o != 3'd0) t = t | c;
            end else begin
                ob = sg;
                a = a << 1;
                if (wb < 32) a = a & ((32'd1 << wb) - 1);
                if (o == 3'd1) a[0] = c;
            end
            c = ob;
        end
        res.r = a; res.n = a[wb-1]; res.z = (a == 0); res.c = c; res.t = t;
        return res;
    endfunction

    task automatic run(input logic [2:0] o, input logic [1:0] w, input logic [31:0] a,
                       input logic [7:0] k, input logic ci, input bit inject);
        ref_t e;
        int L;
        e = ref_op(o, w, a, k, ci);
        L = ref_lat(o, w, k);
        @(negedge clk);
        op = o; width_sel = w; operand = a; count = k; carry_in = ci; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        chk("R9 busy after accept", {31'd0, busy}, 32'd1);
        for (int i = 1; i < L; i++) begin
            if (inject && i == 1) begin
                op = 3'd4; operand = ~a; count = 8'd1; start = 1'b1;
            end
            @(posedge clk); #1;
            start = 1'b0;
            if (i == L - 1) begin
                chk("R1/R2/R3 done early", {31'd0, done}, 32'd0);
                chk("R9 busy before done", {31'd0, busy}, 32'd1);
            end
        end
        @(posedge clk); #1;
        chk((o <= 3'd1 || o >= 3'd5) ? "R3 latency" : (w >= 2 ? "R2 latency" : "R1 latency"),
            {31'd0, done}, 32'd1);
        chk("R9 idle at done", {31'd0, busy}, 32'd0);
        chk((o <= 3'd1) ? "R5 result" : "R4 result", result, e.r);
        chk("R6 carry", {31'd0, flag_c}, {31'd0, e.c});
        chk("R7 sticky", {31'd0, flag_t}, {31'd0, e.t});
        chk("R8 negative", {31'd0, flag_n}, {31'd0, e.n});
        chk("R8 zero", {31'd0, flag_z}, {31'd0, e.z});
        @(posedge clk); #1;
        chk("R9 single done", {31'd0, done}, 32'd0);
        if (inject) chk("R9 ignored start", {31'd0, busy}, 32'd0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        #1;
        chk("R10 busy", {31'd0, busy}, 32'd0);
        chk("R10 done", {31'd0, done}, 32'd0);
        chk("R10 result", result, 32'd0);
        chk("R10 flags", {28'd0, flag_n, flag_z, flag_c, flag_t}, 32'd0);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // directed corners
        run(3'd0, 2'd2, 32'h0000_00A5, 8'd0, 1'b1, 0); // R5 ror, width forced to byte
        run(3'd1, 2'd1, 32'h1234_5681, 8'd9, 1'b0, 0); // R5 rol
        run(3'd2, 2'd0, 32'hFFFF_FF80, 8'd3, 1'b0, 0); // R4 asr byte
        run(3'd2, 2'd1, 32'h0000_8001, 8'd0, 1'b0, 0); // R6 count 0
        run(3'd3, 2'd2, 32'h8000_0007, 8'd2, 1'b0, 0); // R7 sticky set
        run(3'd3, 2'd2, 32'h8000_0004, 8'd3, 1'b0, 0); // R7 only last bit out
        run(3'd4, 2'd1, 32'hFFFF_C001, 8'd1, 1'b0, 0); // R4 lsl word
        run(3'd2, 2'd2, 32'h8000_0000, 8'd200, 1'b0, 0); // R4 saturate sign
        run(3'd3, 2'd0, 32'h0000_00FF, 8'd255, 1'b0, 0); // R4 saturate zero
        run(3'd5, 2'd1, 32'h0000_8003, 8'd77, 1'b0, 0); // R3 fixed ignores count
        run(3'd6, 2'd3, 32'h0000_0003, 8'd0, 1'b0, 0); // R3 fixed lsr
        run(3'd7, 2'd0, 32'h0000_0080, 8'd50, 1'b0, 0); // R3 fixed lsl, zero result
        run(3'd2, 2'd1, 32'h0000_9000, 8'd4, 1'b0, 1); // R9 start during busy
        for (int j = 0; j < 250; j++) begin
            logic [7:0] k;
            k = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 36);
            run(3'($urandom), 2'($urandom), $urandom, k, 1'($urandom), ($urandom % 8) == 0);
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule